// File: doc/BRIEF.md
# Four-Lane Intra Sample Predictor

This block forms intra prediction samples for a video encoder, four samples per clock, from boundary pixels that have already been reconstructed. It serves 4x4 luma blocks in all nine directional, flat and averaging modes, and it serves 16x16 luma and 8x8 chroma blocks in their vertical, horizontal and averaging modes. The surface-fit (plane) mode is not built. The caller presents the boundary pixels, the neighbour availability flags, the block kind, the mode and the position of the wanted four-sample group. The caller pulses `req`, and one clock later the four samples appear with `pred_valid`.

All 4x4 directional modes draw on one shared set of pair sums over the 13-pixel boundary, which runs through the left column, the corner and the above row with its above-right extension. Each two-tap value halves one pair sum. Each three-tap value adds two adjacent pair sums, so neighbouring outputs reuse the same partial sum. Each of the four output lanes then only chooses among the precomputed taps. A 4x4 block takes four requests, one per row. Larger blocks are walked one row and one four-column group at a time.

Top module: `ip4_intra_pred`

## Requirements
- R1: `pred_valid` is high in exactly the cycle after a cycle in which `req` was high, and `pred` is updated in that same cycle. Reset clears `pred_valid` and `pred` to zero.
- R2: Vertical mode (code 0) gives lane j the above pixel in column x, where x is j for 4x4 blocks and grp*4+j for larger blocks. The left pixels and `avail_left` have no effect on it. Above pixel k sits at `above[8k+:8]`, and lane j sits at `pred[8j+:8]`.
- R3: Horizontal mode (code 1) gives all four lanes the left pixel of the addressed row. Left pixel k (row k) sits at `left[8k+:8]`. For 4x4 blocks the row is `row[1:0]`.
- R4: Averaging mode (code 2) with both sides present gives (sum of N above + sum of N left + N) / 2N. N is 4 for `blk_type` 0 (4x4 luma), 16 for `blk_type` 1 (16x16 luma) and 8 for `blk_type` 2 (8x8 chroma).
- R5: Averaging mode with only one side present gives (sum of that side's N pixels + N/2) / N. With neither side present every lane is 128.
- R6: 4x4 modes 3 to 8 follow the standard directional sample rules. The codes are 3 down-left, 4 down-right, 5 vertical-right, 6 horizontal-down, 7 vertical-left and 8 horizontal-up. Two-tap values are (a+b+1)>>1 and three-tap values are (a+2b+c+2)>>2, with the corner pixel taking the place of above[-1] and left[-1].
- R7: When `avail_aright` is low, above pixels 4 to 7 are replaced by above pixel 3 in every 4x4 directional mode.
- R8: The boundary ends fold back on themselves. Down-left at (x=3,y=3) gives (A6+3*A7+2)>>2. Horizontal-up gives (L2+3*L3+2)>>2 at x+2y=5 and L3 where x+2y>5.
- R9: An unsupported combination gives 128 on all lanes. The unsupported cases are `blk_type` 3, a 4x4 mode above 8, and a 16x16 or chroma mode above 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request one four-sample group |
| blk_type | input | 2 | 0 = 4x4 luma, 1 = 16x16 luma, 2 = 8x8 chroma |
| mode | input | 4 | Prediction mode code |
| row | input | 4 | Row index inside the block |
| grp | input | 2 | Four-column group index for larger blocks |
| above | input | 128 | Sixteen above pixels; for 4x4, pixels 4..7 are the above-right ones |
| left | input | 128 | Sixteen left pixels, top row first |
| corner | input | 8 | Above-left corner pixel |
| avail_above | input | 1 | Above row present |
| avail_left | input | 1 | Left column present |
| avail_aright | input | 1 | Above-right pixels present (4x4 only) |
| pred_valid | output | 1 | Samples on `pred` are fresh |
| pred | output | 32 | Four prediction samples, lane j at bits 8j+7:8j |

## Verification
Every result of this block is due one clock edge after the cycle in which `req` is seen high. The edge-tap sums, the averaging unit and the lane choice are all combinational ahead of the single output register. The bench therefore drives a request on a falling edge and compares the lanes on the next falling edge, halfway past the capturing rising edge. On that same falling edge it drops `req`, so each result stands alone. A later falling edge then confirms that `pred_valid` has gone low again.

// File: rtl/ip4_pkg.sv
package ip4_pkg;

   typedef enum logic [1:0] {
      BT_L4  = 2'd0,
      BT_L16 = 2'd1,
      BT_CH8 = 2'd2,
      BT_BAD = 2'd3
   } blk_e;

   localparam logic [3:0] M_VERT = 4'd0;
   localparam logic [3:0] M_HORZ = 4'd1;
   localparam logic [3:0] M_DC   = 4'd2;
   localparam logic [3:0] M_DDL  = 4'd3;
   localparam logic [3:0] M_DDR  = 4'd4;
   localparam logic [3:0] M_VR   = 4'd5;
   localparam logic [3:0] M_HD   = 4'd6;
   localparam logic [3:0] M_VL   = 4'd7;
   localparam logic [3:0] M_HU   = 4'd8;

   // source picked by one output lane
   typedef enum logic [2:0] {
      K_EDGE,
      K_TWO,
      K_THREE,
      K_DC,
      K_ABV,
      K_LFT,
      K_MID
   } src_e;

endpackage

// File: rtl/ip4_edge_taps.sv
// Pair sums over the 4x4 boundary and the two- and three-tap values built on them.
// Boundary order: e[0..3] = L3..L0, e[4] = corner, e[5..12] = A0..A7.
module ip4_edge_taps #(
   parameter int PIX_W = 8,
   parameter int EN    = 13
) (
   input  logic [PIX_W-1:0] e  [EN],
   output logic [PIX_W-1:0] t2 [EN-1],
   output logic [PIX_W-1:0] t3 [EN]
);
   localparam int PS_W = PIX_W + 1;
   localparam int NP   = EN + 1;

   logic [PS_W-1:0] pp [NP];

   // outer pair sums mirror the end pixels
   assign pp[0]    = {e[0], 1'b0};
   assign pp[NP-1] = {e[EN-1], 1'b0};

   generate
      for (genvar k = 1; k < NP - 1; k++) begin : g_pair
         assign pp[k] = {1'b0, e[k-1]} + {1'b0, e[k]};
      end
      for (genvar i = 0; i < EN - 1; i++) begin : g_two
         logic [PS_W-1:0] s2;
         assign s2    = pp[i+1] + PS_W'(1);
         assign t2[i] = s2[PIX_W:1];
      end
      for (genvar c = 0; c < EN; c++) begin : g_three
         logic [PS_W:0] s3;
         assign s3    = {1'b0, pp[c]} + {1'b0, pp[c+1]} + (PS_W+1)'(2);
         assign t3[c] = s3[PS_W:2];
      end
   endgenerate
endmodule

// File: rtl/ip4_dc_unit.sv
// Rounded average over the available boundary sides for all block kinds.
module ip4_dc_unit #(
   parameter int PIX_W  = 8,
   parameter int EDGE_N = 16
) (
   input  logic [1:0]              blk_type,
   input  logic [EDGE_N*PIX_W-1:0] above,
   input  logic [EDGE_N*PIX_W-1:0] left,
   input  logic                    avail_above,
   input  logic                    avail_left,
   output logic [PIX_W-1:0]        dc
);
   import ip4_pkg::*;

   localparam int SUM_W = PIX_W + $clog2(2*EDGE_N) + 1;
   localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W-1));

   logic [SUM_W-1:0] sa4, sa8, sa16, sl4, sl8, sl16;
   logic [SUM_W-1:0] sa, sl, tot;
   int               sh;

   always_comb begin
      sa4 = '0; sl4 = '0;
      for (int k = 0; k < 4; k++) begin
         sa4 = sa4 + SUM_W'(above[k*PIX_W +: PIX_W]);
         sl4 = sl4 + SUM_W'(left[k*PIX_W +: PIX_W]);
      end
      sa8 = sa4; sl8 = sl4;
      for (int k = 4; k < 8; k++) begin
         sa8 = sa8 + SUM_W'(above[k*PIX_W +: PIX_W]);
         sl8 = sl8 + SUM_W'(left[k*PIX_W +: PIX_W]);
      end
      sa16 = sa8; sl16 = sl8;
      for (int k = 8; k < EDGE_N; k++) begin
         sa16 = sa16 + SUM_W'(above[k*PIX_W +: PIX_W]);
         sl16 = sl16 + SUM_W'(left[k*PIX_W +: PIX_W]);
      end
   end

   always_comb begin
      case (blk_type)
         BT_L16:  begin sa = sa16; sl = sl16; sh = 4; end
         BT_CH8:  begin sa = sa8;  sl = sl8;  sh = 3; end
         default: begin sa = sa4;  sl = sl4;  sh = 2; end
      endcase
      tot = '0;
      dc  = MID;
      if (avail_above && avail_left) begin
         tot = (sa + sl + (SUM_W'(1) << sh)) >> (sh + 1);
         dc  = tot[PIX_W-1:0];
      end else if (avail_above) begin
         tot = (sa + (SUM_W'(1) << (sh - 1))) >> sh;
         dc  = tot[PIX_W-1:0];
      end else if (avail_left) begin
         tot = (sl + (SUM_W'(1) << (sh - 1))) >> sh;
         dc  = tot[PIX_W-1:0];
      end
   end
endmodule

// File: rtl/ip4_lane_sel.sv
// One output lane: decides which shared tap feeds column LANE for the request.
module ip4_lane_sel #(
   parameter int PIX_W  = 8,
   parameter int EDGE_N = 16,
   parameter int EN     = 13,
   parameter int LANE   = 0
) (
   input  logic [1:0]              blk_type,
   input  logic [3:0]              mode,
   input  logic [3:0]              row,
   input  logic [1:0]              grp,
   input  logic [PIX_W-1:0]        e  [EN],
   input  logic [PIX_W-1:0]        t2 [EN-1],
   input  logic [PIX_W-1:0]        t3 [EN],
   input  logic [PIX_W-1:0]        dc,
   input  logic [EDGE_N*PIX_W-1:0] above,
   input  logic [EDGE_N*PIX_W-1:0] left,
   output logic [PIX_W-1:0]        px
);
   import ip4_pkg::*;

   localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W-1));

   src_e       kind;
   logic [3:0] ix;
   logic [3:0] col;
   int         x, y, z;

   assign col = {grp, 2'(LANE)};

   always_comb begin
      kind = K_MID;
      ix   = '0;
      x    = LANE;
      y    = int'(row[1:0]);
      z    = 0;
      if (blk_type == BT_L4) begin
         case (mode)
            M_VERT: begin kind = K_EDGE;  ix = 4'(5 + x); end
            M_HORZ: begin kind = K_EDGE;  ix = 4'(3 - y); end
            M_DC:   kind = K_DC;
            M_DDL:  begin kind = K_THREE; ix = 4'(6 + x + y); end
            M_DDR:  begin kind = K_THREE; ix = 4'(4 + x - y); end
            M_VR: begin
               z = 2*x - y;
               if (z >= 0 && (z & 1) == 0) begin kind = K_TWO;   ix = 4'(4 + x - (y >> 1)); end
               else if (z >= 0)            begin kind = K_THREE; ix = 4'(4 + x - (y >> 1)); end
               else if (z == -1)           begin kind = K_THREE; ix = 4'd4; end
               else                        begin kind = K_THREE; ix = 4'(5 - y); end
            end
            M_HD: begin
               z = 2*y - x;
               if (z >= 0 && (z & 1) == 0) begin kind = K_TWO;   ix = 4'(3 - y + (x >> 1)); end
               else if (z >= 0)            begin kind = K_THREE; ix = 4'(4 - y + (x >> 1)); end
               else if (z == -1)           begin kind = K_THREE; ix = 4'd4; end
               else                        begin kind = K_THREE; ix = 4'(3 + x); end
            end
            M_VL: begin
               if ((y & 1) == 0) begin kind = K_TWO;   ix = 4'(5 + x + (y >> 1)); end
               else              begin kind = K_THREE; ix = 4'(6 + x + (y >> 1)); end
            end
            M_HU: begin
               z = x + 2*y;
               if (z > 5)                  begin kind = K_EDGE;  ix = 4'd0; end
               else if (z == 5)            begin kind = K_THREE; ix = 4'd0; end
               else if ((z & 1) == 0)      begin kind = K_TWO;   ix = 4'(2 - y - (x >> 1)); end
               else                        begin kind = K_THREE; ix = 4'(2 - y - (x >> 1)); end
            end
            default: kind = K_MID;
         endcase
      end else if (blk_type == BT_L16 || blk_type == BT_CH8) begin
         case (mode)
            M_VERT:  kind = K_ABV;
            M_HORZ:  kind = K_LFT;
            M_DC:    kind = K_DC;
            default: kind = K_MID;
         endcase
      end
   end

   always_comb begin
      case (kind)
         K_EDGE:  px = e[ix];
         K_TWO:   px = t2[ix];
         K_THREE: px = t3[ix];
         K_DC:    px = dc;
         K_ABV:   px = above[col*PIX_W +: PIX_W];
         K_LFT:   px = left[row*PIX_W +: PIX_W];
         default: px = MID;
      endcase
   end
endmodule

// File: rtl/ip4_intra_pred.sv
module ip4_intra_pred #(
   parameter int PIX_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [1:0]           blk_type,
   input  logic [3:0]           mode,
   input  logic [3:0]           row,
   input  logic [1:0]           grp,
   input  logic [16*PIX_W-1:0]  above,
   input  logic [16*PIX_W-1:0]  left,
   input  logic [PIX_W-1:0]     corner,
   input  logic                 avail_above,
   input  logic                 avail_left,
   input  logic                 avail_aright,
   output logic                 pred_valid,
   output logic [4*PIX_W-1:0]   pred
);
   localparam int EDGE_N = 16;
   localparam int LANES  = 4;
   localparam int EN     = 2*LANES + LANES + 1;

   generate
      if (PIX_W < 4 || PIX_W > 14) begin : g_bad_width
         $error("ip4_intra_pred: PIX_W must lie in 4..14");
      end
   endgenerate

   logic [PIX_W-1:0]       e  [EN];
   logic [PIX_W-1:0]       t2 [EN-1];
   logic [PIX_W-1:0]       t3 [EN];
   logic [PIX_W-1:0]       dc;
   logic [LANES*PIX_W-1:0] lanes;

   // 4x4 boundary: left column reversed, corner, above with above-right fill
   always_comb begin
      for (int k = 0; k < LANES; k++)
         e[LANES-1-k] = left[k*PIX_W +: PIX_W];
      e[LANES] = corner;
      for (int k = 0; k < 2*LANES; k++)
         e[LANES+1+k] = (k >= LANES && !avail_aright) ? above[(LANES-1)*PIX_W +: PIX_W]
                                                      : above[k*PIX_W +: PIX_W];
   end

   ip4_edge_taps #(.PIX_W(PIX_W), .EN(EN)) u_taps (
      .e  (e),
      .t2 (t2),
      .t3 (t3)
   );

   ip4_dc_unit #(.PIX_W(PIX_W), .EDGE_N(EDGE_N)) u_dc (
      .blk_type    (blk_type),
      .above       (above),
      .left        (left),
      .avail_above (avail_above),
      .avail_left  (avail_left),
      .dc          (dc)
   );

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         ip4_lane_sel #(.PIX_W(PIX_W), .EDGE_N(EDGE_N), .EN(EN), .LANE(j)) u_sel (
            .blk_type (blk_type),
            .mode     (mode),
            .row      (row),
            .grp      (grp),
            .e        (e),
            .t2       (t2),
            .t3       (t3),
            .dc       (dc),
            .above    (above),
            .left     (left),
            .px       (lanes[j*PIX_W +: PIX_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_valid <= 1'b0;
         pred       <= '0;
      end else begin
         pred_valid <= req;
         if (req) pred <= lanes;
      end
   end
endmodule

// File: rtl/ip4_intra_pred_chk.sv
module ip4_intra_pred_chk #(
   parameter int PIX_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req,
   input logic [1:0]           blk_type,
   input logic [3:0]           mode,
   input logic [3:0]           row,
   input logic [1:0]           grp,
   input logic [16*PIX_W-1:0]  above,
   input logic [16*PIX_W-1:0]  left,
   input logic [PIX_W-1:0]     corner,
   input logic                 avail_above,
   input logic                 avail_left,
   input logic                 avail_aright,
   input logic                 pred_valid,
   input logic [4*PIX_W-1:0]   pred
);
   localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W-1));

   logic [PIX_W-1:0] acol, lrow;
   logic             big, bad;

   assign acol = above[{grp, 2'b00}*PIX_W +: PIX_W];
   assign lrow = left[row*PIX_W +: PIX_W];
   assign big  = (blk_type == 2'd1) || (blk_type == 2'd2);
   assign bad  = (blk_type == 2'd3) || (blk_type == 2'd0 && mode > 4'd8) ||
                 (big && mode > 4'd2);

   a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> pred_valid);

   a_r1_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !pred_valid);

   a_r2_vert_col: assert property (@(posedge clk) disable iff (!rst_n)
      (req && big && mode == 4'd0) |=> pred[PIX_W-1:0] == $past(acol));

   a_r3_horz_row: assert property (@(posedge clk) disable iff (!rst_n)
      (req && big && mode == 4'd1) |=> pred == {4{$past(lrow)}});

   a_r5_dc_none: assert property (@(posedge clk) disable iff (!rst_n)
      (req && blk_type != 2'd3 && mode == 4'd2 && !avail_above && !avail_left)
      |=> pred == {4{MID}});

   a_r9_bad_combo: assert property (@(posedge clk) disable iff (!rst_n)
      (req && bad) |=> pred == {4{MID}});
endmodule

bind ip4_intra_pred ip4_intra_pred_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/sim_ip4_intra_pred.sv
module sim_ip4_intra_pred;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 1'b0;
   logic [1:0]   blk_type = '0;
   logic [3:0]   mode = '0;
   logic [3:0]   row = '0;
   logic [1:0]   grp = '0;
   logic [127:0] above = '0;
   logic [127:0] left = '0;
   logic [7:0]   corner = '0;
   logic         avail_above = 1'b1;
   logic         avail_left = 1'b1;
   logic         avail_aright = 1'b1;
   logic         pred_valid;
   logic [31:0]  pred;

   int ab [16];
   int lf [16];
   int cq;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ip4_intra_pred u0 (.*);

   // {blk_type[1:0], mode[3:0], row[3:0], grp[1:0]}
   localparam logic [11:0] VEC [0:13] = '{
      {2'd0, 4'd0, 4'd2, 2'd0}, {2'd0, 4'd1, 4'd3, 2'd0},
      {2'd0, 4'd2, 4'd0, 2'd0}, {2'd0, 4'd4, 4'd1, 2'd0},
      {2'd0, 4'd6, 4'd2, 2'd0}, {2'd0, 4'd7, 4'd3, 2'd0},
      {2'd1, 4'd0, 4'd5, 2'd3}, {2'd1, 4'd1, 4'd15, 2'd1},
      {2'd1, 4'd2, 4'd9, 2'd2}, {2'd2, 4'd0, 4'd7, 2'd1},
      {2'd2, 4'd1, 4'd6, 2'd0}, {2'd2, 4'd2, 4'd4, 2'd1},
      {2'd0, 4'd9, 4'd0, 2'd0}, {2'd1, 4'd3, 4'd0, 2'd0}
   };

   function automatic int pa(int k);
      if (k < 0) return cq;
      if (k >= 4 && !avail_aright) return ab[3];
      return ab[k];
   endfunction

   function automatic int pl(int k);
      if (k < 0) return cq;
      return lf[k];
   endfunction

   function automatic int f2(int a, int b);
      return (a + b + 1) >> 1;
   endfunction

   function automatic int f3(int a, int b, int c);
      return (a + 2*b + c + 2) >> 2;
   endfunction

   function automatic int model(int bt, int md, int rw, int gp, int x);
      int n, sa, sl, y, z;
      if (bt == 3) return 128;
      if (bt != 0 && md > 2) return 128;
      if (bt == 0 && md > 8) return 128;
      n = (bt == 0) ? 4 : (bt == 1) ? 16 : 8;
      y = (bt == 0) ? (rw % 4) : rw;
      if (md == 0) return (bt == 0) ? ab[x] : ab[gp*4 + x];
      if (md == 1) return lf[y];
      if (md == 2) begin
         sa = 0; sl = 0;
         for (int k = 0; k < n; k++) begin sa += ab[k]; sl += lf[k]; end
         if (avail_above && avail_left) return (sa + sl + n) / (2*n);
         if (avail_above) return (sa + n/2) / n;
         if (avail_left)  return (sl + n/2) / n;
         return 128;
      end
      case (md)
         3: if (x == 3 && y == 3) return (pa(6) + 3*pa(7) + 2) >> 2;
            else return f3(pa(x+y), pa(x+y+1), pa(x+y+2));
         4: if (x > y) return f3(pa(x-y-2), pa(x-y-1), pa(x-y));
            else if (x < y) return f3(pl(y-x-2), pl(y-x-1), pl(y-x));
            else return f3(pa(0), cq, pl(0));
         5: begin
            z = 2*x - y;
            if (z >= 0 && z % 2 == 0) return f2(pa(x-(y>>1)-1), pa(x-(y>>1)));
            if (z >= 0) return f3(pa(x-(y>>1)-2), pa(x-(y>>1)-1), pa(x-(y>>1)));
            if (z == -1) return f3(pl(0), cq, pa(0));
            return f3(pl(y-1), pl(y-2), pl(y-3));
         end
         6: begin
            z = 2*y - x;
            if (z >= 0 && z % 2 == 0) return f2(pl(y-(x>>1)-1), pl(y-(x>>1)));
            if (z >= 0) return f3(pl(y-(x>>1)-2), pl(y-(x>>1)-1), pl(y-(x>>1)));
            if (z == -1) return f3(pl(0), cq, pa(0));
            return f3(pa(x-1), pa(x-2), pa(x-3));
         end
         7: if (y % 2 == 0) return f2(pa(x+(y>>1)), pa(x+(y>>1)+1));
            else return f3(pa(x+(y>>1)), pa(x+(y>>1)+1), pa(x+(y>>1)+2));
         default: begin
            z = x + 2*y;
            if (z > 5) return lf[3];
            if (z == 5) return (lf[2] + 3*lf[3] + 2) >> 2;
            if (z % 2 == 0) return f2(pl(y+(x>>1)), pl(y+(x>>1)+1));
            return f3(pl(y+(x>>1)), pl(y+(x>>1)+1), pl(y+(x>>1)+2));
         end
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic load_pat(input int p);
      for (int k = 0; k < 16; k++) begin
         ab[k] = (p == 2) ? 255 : (37*k + 91*p + 13) % 256;
         lf[k] = (p == 2) ? 255 : (53*k + 29*p + 200) % 256;
      end
      cq = (p == 2) ? 255 : (71*p + 5) % 256;
   endtask

   task automatic run(input int bt, input int md, input int rw, input int gp, input string tag);
      @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         above[8*k +: 8] = 8'(ab[k]);
         left[8*k +: 8]  = 8'(lf[k]);
      end
      corner   = 8'(cq);
      blk_type = 2'(bt);
      mode     = 4'(md);
      row      = 4'(rw);
      grp      = 2'(gp);
      req      = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk({tag, " valid"}, int'(pred_valid), 1);
      for (int j = 0; j < 4; j++)
         chk($sformatf("%s bt%0d m%0d r%0d g%0d lane%0d", tag, bt, md, rw, gp, j),
             int'(pred[8*j +: 8]), model(bt, md, rw, gp, j));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      load_pat(0);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset valid", int'(pred_valid), 0);
      chk("R1 reset pred", int'(pred), 0);
      rst_n = 1'b1;

      // vector table walk over three boundary patterns
      for (int p = 0; p < 3; p++) begin
         load_pat(p);
         for (int v = 0; v < 14; v++)
            run(int'(VEC[v][11:10]), int'(VEC[v][9:6]), int'(VEC[v][5:2]),
                int'(VEC[v][1:0]), "R2 R3 R4 R9 table");
      end

      // R1: valid drops the cycle after req drops
      @(negedge clk);
      chk("R1 idle valid", int'(pred_valid), 0);

      // R6 and R8: every 4x4 directional mode, every row
      load_pat(1);
      for (int md = 3; md < 9; md++)
         for (int r = 0; r < 4; r++) run(0, md, r, 0, "R6 R8 sweep");

      // R7: above-right missing
      avail_aright = 1'b0;
      for (int md = 3; md < 9; md++)
         for (int r = 0; r < 4; r++) run(0, md, r, 0, "R7 aright off");
      avail_aright = 1'b1;

      // R8: folded ends against hand values
      load_pat(0);
      run(0, 3, 3, 0, "R8 ddl corner");
      chk("R8 ddl end", int'(pred[31:24]), (ab[6] + 3*ab[7] + 2) >> 2);
      run(0, 8, 2, 0, "R8 hu tail");
      chk("R8 hu z5", int'(pred[15:8]), (lf[2] + 3*lf[3] + 2) >> 2);
      chk("R8 hu flat", int'(pred[31:24]), lf[3]);

      // R4 and R5: averaging under each availability mix
      for (int bt = 0; bt < 3; bt++)
         for (int av = 0; av < 4; av++) begin
            avail_above = av[0];
            avail_left  = av[1];
            run(bt, 2, 1, 0, (av == 3) ? "R4 dc both" : "R5 dc partial");
         end
      avail_above = 1'b0; avail_left = 1'b0;
      run(1, 2, 0, 0, "R5 dc none");
      chk("R5 dc none 128", int'(pred[7:0]), 128);
      avail_above = 1'b1; avail_left = 1'b1;

      // R2: vertical ignores the left side and its flag
      avail_left = 1'b0;
      for (int k = 0; k < 16; k++) lf[k] = 255 - k;
      run(0, 0, 1, 0, "R2 vert no left");
      run(1, 0, 7, 2, "R2 vert no left big");
      avail_left = 1'b1;

      // R9: unsupported combinations
      run(3, 0, 0, 0, "R9 bad type");
      run(2, 4, 0, 0, "R9 bad chroma mode");
      chk("R9 bad lane", int'(pred[7:0]), 128);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule